// File: doc/BRIEF.md
# Table-Driven Two-Bit State Machine

This block is a small state machine whose entire behaviour comes from configuration. It holds two state bits and watches two external inputs, each picked from a 32-bit source bus by a 5-bit select code. Three 16-bit truth tables define its behaviour. One table gives the next value of the low state bit, one gives the next value of the high state bit, and one gives a combinational output. All three tables are looked up with the same 4-bit index, so a toggle flip-flop, a two-bit counter or an edge detector is loaded as data, not built as logic.

Software loads the tables and the input selects through a narrow write port while the run enable is low. It then raises the run enable. From that point the state advances on every clock, and writes to the configuration are dropped until the machine is stopped again.

Top module: `tbl_fsm2`

## Requirements
- R1: While `rst` is high at a rising edge, the state, all three tables and both select codes are cleared. After reset the state reads 00 and `lut_out` reads 0.
- R2: The lookup index is {ext1, ext0, state[1], state[0]}, with state[0] as bit 0. Bit k of a table is the function value when the index equals k.
- R3: `lut_out` equals bit [index] of the output table. It follows the current inputs and state within the same cycle, with no register between them.
- R4: At a rising edge with `run_en` high, state[0] takes bit [index] of the low-bit next-state table.
- R5: At a rising edge with `run_en` high, state[1] takes bit [index] of the high-bit next-state table. When that table holds 0x0000, state[1] stays at 0.
- R6: At a rising edge with `run_en` low, the state holds its value.
- R7: A write (`cfg_we` high) is taken only while `run_en` is low. `cfg_addr` 0 loads the low-bit next-state table, 1 loads the high-bit next-state table, 2 loads the output table, and 3 loads the selects from `cfg_wdata` [4:0] for ext0 and [9:5] for ext1. A write made while `run_en` is high changes nothing.
- R8: Select code 0 gives a constant 0, whatever `src_bus` [0] holds. A code k from 1 to 31 gives `src_bus` [k].
- R9: With the output table at 0xAAAA, the low-bit next-state table at 0x5A5A and ext0 selected, the machine behaves as a toggle flip-flop. `lut_out` follows state[0], and state[0] inverts on each enabled edge where ext0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable: state advances when 1, configuration is open when 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target: 0 low-bit table, 1 high-bit table, 2 output table, 3 selects |
| cfg_wdata | input | 16 | Configuration write data |
| src_bus | input | 32 | Source signals the two external inputs are picked from |
| state_q | output | 2 | Current state bits, with state[0] in bit 0 |
| lut_out | output | 1 | Combinational table output |

## Verification
Two things can happen on the same edge: a configuration write and a state advance. Either the write is dropped because the machine is running, or the write lands while the state is held. The bench provokes both cases by asserting `cfg_we` with random data together with a random `run_en` on many cycles while the source bus changes. A reference model updates its tables only when the enable is low and its state only when the enable is high. The state and `lut_out` are then compared with the model on every cycle. A write that wrongly landed during a run shows up as a change in `lut_out` or in the next state.

// File: rtl/tfsm_pkg.sv
package tfsm_pkg;

    localparam int SEL_W  = 5;
    localparam int SRC_N  = 1 << SEL_W;
    localparam int ST_W   = 2;
    localparam int EXT_N  = 2;
    localparam int IDX_W  = ST_W + EXT_N;
    localparam int TBL_W  = 1 << IDX_W;
    localparam int ADDR_W = 2;
    localparam int DATA_W = TBL_W;

    typedef logic [TBL_W-1:0] tbl_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [ADDR_W-1:0] {
        CFG_NEXT_LO = 2'd0,
        CFG_NEXT_HI = 2'd1,
        CFG_OUT_TBL = 2'd2,
        CFG_SELECTS = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        tbl_t nxt_lo;
        tbl_t nxt_hi;
        tbl_t out_tbl;
        sel_t sel_hi;
        sel_t sel_lo;
    } cfg_t;

    typedef struct packed {
        logic ext1;
        logic ext0;
        logic st1;
        logic st0;
    } idx_t;

    function automatic logic tbl_bit(input tbl_t t, input idx_t i);
        return t[i];
    endfunction

endpackage

// File: rtl/tfsm_cfg_regs.sv
module tfsm_cfg_regs
    import tfsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output cfg_t              cfg_q
);

    logic      wr_ok;
    cfg_addr_e addr_e;

    assign wr_ok  = cfg_we && !run_en;
    assign addr_e = cfg_addr_e'(cfg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            unique case (addr_e)
                CFG_NEXT_LO: cfg_q.nxt_lo  <= cfg_wdata;
                CFG_NEXT_HI: cfg_q.nxt_hi  <= cfg_wdata;
                CFG_OUT_TBL: cfg_q.out_tbl <= cfg_wdata;
                CFG_SELECTS: begin
                    cfg_q.sel_lo <= cfg_wdata[SEL_W-1:0];
                    cfg_q.sel_hi <= cfg_wdata[2*SEL_W-1:SEL_W];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tfsm_src_mux.sv
module tfsm_src_mux
    import tfsm_pkg::*;
(
    input  sel_t             sel,
    input  logic [SRC_N-1:0] src_bus,
    output logic             ext
);

    always_comb begin
        if (sel == '0) ext = 1'b0;
        else           ext = src_bus[sel];
    end

endmodule

// File: rtl/tfsm_state.sv
module tfsm_state
    import tfsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  cfg_t             cfg_q,
    input  logic [EXT_N-1:0] ext,
    output logic [ST_W-1:0]  state_q,
    output logic             lut_out
);

    idx_t            idx;
    logic [ST_W-1:0] state_d;

    always_comb begin
        idx.ext1 = ext[1];
        idx.ext0 = ext[0];
        idx.st1  = state_q[1];
        idx.st0  = state_q[0];
        state_d[0] = tbl_bit(cfg_q.nxt_lo, idx);
        state_d[1] = tbl_bit(cfg_q.nxt_hi, idx);
        lut_out    = tbl_bit(cfg_q.out_tbl, idx);
    end

    always_ff @(posedge clk) begin
        if (rst)         state_q <= '0;
        else if (run_en) state_q <= state_d;
    end

endmodule

// File: rtl/tbl_fsm2.sv
module tbl_fsm2
    import tfsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [SRC_N-1:0]  src_bus,
    output logic [ST_W-1:0]   state_q,
    output logic              lut_out
);

    cfg_t             cfg_q;
    logic [EXT_N-1:0] ext_sel;
    sel_t             sel_arr [EXT_N];

    assign sel_arr[0] = cfg_q.sel_lo;
    assign sel_arr[1] = cfg_q.sel_hi;

    tfsm_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    for (genvar g = 0; g < EXT_N; g++) begin : g_mux
        tfsm_src_mux u_mux (
            .sel     (sel_arr[g]),
            .src_bus (src_bus),
            .ext     (ext_sel[g])
        );
    end

    tfsm_state u_state (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .cfg_q   (cfg_q),
        .ext     (ext_sel),
        .state_q (state_q),
        .lut_out (lut_out)
    );

endmodule

// File: rtl/tfsm_chk.sv
module tfsm_chk
    import tfsm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             cfg_we,
    input cfg_t             cfg_q,
    input logic [EXT_N-1:0] ext_sel,
    input logic [ST_W-1:0]  state_q,
    input logic             lut_out
);

    logic [IDX_W-1:0] idx;
    assign idx = {ext_sel, state_q};

    assert_out_lookup_R3: assert property (@(posedge clk) disable iff (rst)
        lut_out == cfg_q.out_tbl[idx]);

    assert_next_lo_R4: assert property (@(posedge clk) disable iff (rst)
        run_en |=> state_q[0] == $past(cfg_q.nxt_lo[idx]));

    assert_next_hi_R5: assert property (@(posedge clk) disable iff (rst)
        run_en |=> state_q[1] == $past(cfg_q.nxt_hi[idx]));

    assert_zero_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (run_en && cfg_q.nxt_hi == '0) |=> state_q[1] == 1'b0);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(state_q));

    assert_write_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (run_en && cfg_we) |=> $stable(cfg_q));

    assert_sel_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.sel_lo == '0) |-> ext_sel[0] == 1'b0);

endmodule

bind tbl_fsm2 tfsm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .cfg_we  (cfg_we),
    .cfg_q   (cfg_q),
    .ext_sel (ext_sel),
    .state_q (state_q),
    .lut_out (lut_out)
);

// File: tb/tbl_fsm2_test.sv
module tbl_fsm2_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        run_en;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic [31:0] src_bus;
    logic [1:0]  state_q;
    logic        lut_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference model
    logic [15:0] m_lo, m_hi, m_out;
    logic [4:0]  m_s0, m_s1;
    logic [1:0]  m_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbl_fsm2 uut (
        .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .src_bus(src_bus),
        .state_q(state_q), .lut_out(lut_out)
    );

    function automatic logic pick(input logic [4:0] code, input logic [31:0] bus);
        return (code == 5'd0) ? 1'b0 : bus[code];
    endfunction

    function automatic logic [3:0] m_index(input logic [31:0] bus);
        return {pick(m_s1, bus), pick(m_s0, bus), m_st};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check, then advance the model across the edge
    task automatic step(input logic en, input logic we, input logic [1:0] a,
                        input logic [15:0] d, input logic [31:0] bus, input string req);
        logic [3:0] ix;
        logic [1:0] nst;
        @(negedge clk);
        run_en = en; cfg_we = we; cfg_addr = a; cfg_wdata = d; src_bus = bus;
        #1;
        ix = m_index(bus);
        check({req, "/R3 lut_out"}, {31'd0, lut_out}, {31'd0, m_out[ix]});
        check({req, "/R2 state"}, {30'd0, state_q}, {30'd0, m_st});
        nst = en ? {m_hi[ix], m_lo[ix]} : m_st;
        @(posedge clk);
        m_st = nst;
        if (we && !en) begin
            case (a)
                2'd0: m_lo  = d;
                2'd1: m_hi  = d;
                2'd2: m_out = d;
                default: begin m_s0 = d[4:0]; m_s1 = d[9:5]; end
            endcase
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        step(1'b0, 1'b1, a, d, 32'h0, "R7");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; run_en = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0;
        cfg_wdata = 16'h0; src_bus = 32'h0;
        m_lo = 0; m_hi = 0; m_out = 0; m_s0 = 0; m_s1 = 0; m_st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 reset state", {30'd0, state_q}, 32'd0);
        check("R1 reset lut_out", {31'd0, lut_out}, 32'd0);

        // R9 toggle flip-flop, ext0 from src_bus[3]
        cfg_write(2'd2, 16'hAAAA);
        cfg_write(2'd0, 16'h5A5A);
        cfg_write(2'd1, 16'h0000);
        cfg_write(2'd3, 16'h0003);
        for (int i = 0; i < 12; i++)
            step(1'b1, 1'b0, 2'd0, 16'h0, (i % 3 != 0) ? 32'h8 : 32'h0, "R9 toggle");
        // R5 zero table keeps state[1] low
        check("R5 hi stays 0", {31'd0, state_q[1]}, 32'd0);

        // R8 code 0 ignores src_bus[0]
        step(1'b0, 1'b0, 2'd0, 16'h0, 32'h0, "R6 hold");
        cfg_write(2'd3, 16'h0000);
        cfg_write(2'd2, 16'hFF00);    // output = ext1 when sel1 = 0 -> 0
        step(1'b1, 1'b0, 2'd0, 16'h0, 32'hFFFF_FFFF, "R8 code0");
        check("R8 code0 lut_out", {31'd0, lut_out}, 32'd0);

        // R7 writes while running are dropped
        step(1'b1, 1'b1, 2'd2, 16'h00FF, 32'h0, "R7 blocked");
        step(1'b1, 1'b0, 2'd0, 16'h0, 32'h0, "R7 after");

        // random mix of enables, writes and source activity
        for (int i = 0; i < 3000; i++) begin
            logic en, we;
            en = ($urandom % 3) != 0;
            we = ($urandom % 4) == 0;
            step(en, we, 2'($urandom), 16'($urandom), $urandom, "R4 R5 R6 random");
        end

        // R1 reset mid-run clears everything
        @(negedge clk); rst = 1'b1; run_en = 1'b0; cfg_we = 1'b0;
        @(posedge clk); @(negedge clk); rst = 1'b0; src_bus = 32'hFFFF_FFFF;
        m_lo = 0; m_hi = 0; m_out = 0; m_s0 = 0; m_s1 = 0; m_st = 0;
        #1;
        check("R1 re-reset state", {30'd0, state_q}, 32'd0);
        check("R1 re-reset lut_out", {31'd0, lut_out}, 32'd0);
        finish_run();
    end

endmodule